// File: doc/BRIEF.md
# Scatter-Gather Copy Engine with Register-Loaded Descriptor Table

This block is a bus-mastering copy engine. Software fills a small on-chip table with fragment descriptors through a word-addressed register write port. Each descriptor holds a start address and a length, both counted in 32-bit words. Software then sets the fragment count and writes the start bit. The engine walks the valid entries from index 0 upward. It moves every word of every fragment between a single memory request/response port and a streaming port, and software takes no action between fragments.

In memory-to-stream mode the engine reads each word and presents it on the outgoing stream. In stream-to-memory mode it writes each incoming stream word to memory. When the last fragment completes, the engine sets a sticky done flag in its status register and raises a level interrupt. Software may poll the status register or wait for the interrupt. A start with an invalid fragment count sets an error flag instead, and the engine performs no memory access.

Register offsets, in words: control at 0x00, status at 0x01, fragment count at 0x02. Descriptor i has its address at 0x20+2i and its length at 0x21+2i.

Top module: `sg_dma_engine`

## Requirements
- R1: Descriptor address words (offset 0x20+2i), descriptor length words (offset 0x21+2i) and the fragment count (offset 0x02) can be written while idle and read back unchanged on `reg_rdata`. Reset clears all of them to 0.
- R2: Writing control (offset 0x00) with bit 0 set while idle and with a count of 1 to 16 starts a transfer. The busy flag (status bit 0) reads 1 from the cycle after that write until the transfer ends. While idle, `mem_req` is low.
- R3: With control bit 1 = 0 (memory to stream), the engine issues reads in table order. The read addresses form the concatenation of all fragments. Each returned word appears on `strm_out_data`, in the same order, and stays stable until `strm_out_ready` accepts it.
- R4: With control bit 1 = 1 (stream to memory), each accepted `strm_in_data` word is written with `mem_we` high. The words go to the concatenated fragment addresses, in order.
- R5: Within a fragment, the address starts at the descriptor address and advances by one word per granted beat. A read request holds its address until `mem_gnt` is high.
- R6: A fragment of length 0 causes no memory access. The engine continues with the next entry.
- R7: The interrupt stays low while any programmed word remains to be moved. After the last word, done (status bit 1) and `irq` rise in the same cycle in which busy falls.
- R8: `irq` and done stay high until software writes status with bit 1 set. Writing status with only bit 2 set leaves them high.
- R9: A start with a count of 0, or with a count above 16, sets error (status bit 2). It leaves busy at 0 and issues no memory request. Writing status with bit 2 set clears error.
- R10: While busy, writes to the descriptor table, to the count register and to control have no effect.
- R11: A transfer with all 16 table entries moves every entry in index order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word offset for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Completion interrupt, level, follows done flag |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Word address of the beat |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Memory accepts the beat this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| strm_out_valid | output | 1 | Outgoing stream word valid |
| strm_out_data | output | 32 | Outgoing stream word |
| strm_out_ready | input | 1 | Outgoing stream consumer ready |
| strm_in_valid | input | 1 | Incoming stream word valid |
| strm_in_data | input | 32 | Incoming stream word |
| strm_in_ready | output | 1 | Incoming word taken this cycle |

## Verification
The main copy path is driven in both directions. Memory grants are irregular and the outgoing stream stalls periodically, so ordering and data holding are exercised under backpressure. The fragment patterns cover short scattered fragments of unequal length, a zero-length entry between two real ones, a single long fragment, and the full 16-entry table. Together these separate a walker that skips, repeats or reorders entries from one that only mishandles fragment boundaries. An access to an address the bench did not expect, or a read word returned to the stream with the wrong value, is caught in the same cycle. A start with count 0 or 17, and writes made mid-transfer, show whether the guards on count and on busy hold.

// File: rtl/sg_dma_pkg.sv
// Package: register offsets and walker state encoding shared by the
// scatter-gather engine modules. Assumes word-addressed registers.
package sg_dma_pkg;
    localparam int OFS_CTRL   = 0;
    localparam int OFS_STATUS = 1;
    localparam int OFS_COUNT  = 2;

    typedef enum logic [2:0] {
        WK_IDLE,
        WK_LOAD,
        WK_RUN,
        WK_WAIT,
        WK_PUSH,
        WK_NEXT
    } walk_state_t;
endpackage

// File: rtl/sg_dma_regs.sv
// Register file and descriptor table. Holds control, count, sticky status
// and the fragment table, decodes starts and rejects invalid counts.
// Assumes: register data is 32 bits and ADDR_W, LEN_W do not exceed it.
module sg_dma_regs
    import sg_dma_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 16,
    parameter int MAX_FRAG = 16,
    localparam int IDX_W   = $clog2(MAX_FRAG),
    localparam int CNT_W   = $clog2(MAX_FRAG + 1),
    localparam int REG_AW  = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              busy,
    input  logic              finish,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              start,
    output logic              dir,
    output logic [CNT_W-1:0]  count,
    output logic [ADDR_W-1:0] desc_addr,
    output logic [LEN_W-1:0]  desc_len,
    output logic              done,
    output logic              err
);
    logic [ADDR_W-1:0] tbl_addr [MAX_FRAG];
    logic [LEN_W-1:0]  tbl_len  [MAX_FRAG];
    logic [CNT_W-1:0]  cnt_q;
    logic              dir_q, done_q, err_q;

    logic             tbl_sel, ctrl_wr, stat_wr, cnt_wr, start_try, cnt_ok;
    logic [IDX_W-1:0] w_idx;

    // Decode of the write address and the start attempt
    always_comb begin
        tbl_sel   = addr[REG_AW-1];
        w_idx     = addr[IDX_W:1];
        ctrl_wr   = wr_en && (addr == REG_AW'(OFS_CTRL));
        stat_wr   = wr_en && (addr == REG_AW'(OFS_STATUS));
        cnt_wr    = wr_en && (addr == REG_AW'(OFS_COUNT)) && !busy;
        start_try = ctrl_wr && wdata[0] && !busy;
        cnt_ok    = (cnt_q != '0) && (cnt_q <= CNT_W'(MAX_FRAG));
    end

    assign start = start_try && cnt_ok;

    // Descriptor table storage, writable only while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_FRAG; i++) begin
                tbl_addr[i] <= '0;
                tbl_len[i]  <= '0;
            end
        end else if (wr_en && tbl_sel && !busy) begin
            if (addr[0]) tbl_len[w_idx]  <= wdata[LEN_W-1:0];
            else         tbl_addr[w_idx] <= wdata[ADDR_W-1:0];
        end
    end

    // Count, direction and sticky status flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            dir_q  <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (cnt_wr)    cnt_q <= wdata[CNT_W-1:0];
            if (start_try) dir_q <= wdata[1];
            if (finish)                   done_q <= 1'b1;
            else if (stat_wr && wdata[1]) done_q <= 1'b0;
            if (start_try && !cnt_ok)     err_q  <= 1'b1;
            else if (stat_wr && wdata[2]) err_q  <= 1'b0;
        end
    end

    // Register read multiplexer
    always_comb begin
        rdata = '0;
        if (tbl_sel) begin
            rdata = addr[0] ? 32'(tbl_len[w_idx]) : 32'(tbl_addr[w_idx]);
        end else if (addr == REG_AW'(OFS_CTRL)) begin
            rdata = {30'd0, dir_q, 1'b0};
        end else if (addr == REG_AW'(OFS_STATUS)) begin
            rdata = {29'd0, err_q, done_q, busy};
        end else if (addr == REG_AW'(OFS_COUNT)) begin
            rdata = 32'(cnt_q);
        end
    end

    assign dir       = dir_q;
    assign count     = cnt_q;
    assign done      = done_q;
    assign err       = err_q;
    assign desc_addr = tbl_addr[rd_idx];
    assign desc_len  = tbl_len[rd_idx];
endmodule

// File: rtl/sg_dma_walker.sv
// Fragment walker: steps through the table entries, loads the address and
// length counters per fragment and moves one word per granted beat.
// Assumes: one read outstanding at a time; dir and count stay stable while busy.
module sg_dma_walker
    import sg_dma_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 16,
    parameter int DATA_W   = 32,
    parameter int MAX_FRAG = 16,
    localparam int IDX_W   = $clog2(MAX_FRAG),
    localparam int CNT_W   = $clog2(MAX_FRAG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir,
    input  logic [CNT_W-1:0]  count,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [ADDR_W-1:0] desc_addr,
    input  logic [LEN_W-1:0]  desc_len,
    output logic              busy,
    output logic              finish,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready
);
    walk_state_t       st_q;
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] cur_addr_q;
    logic [LEN_W-1:0]  cur_len_q;
    logic [DATA_W-1:0] hold_q;
    logic              last_ent, beat_live, beat_take;

    // Beat qualification and last-entry detection
    always_comb begin
        last_ent  = (CNT_W'(idx_q) + CNT_W'(1)) == count;
        beat_live = (st_q == WK_RUN) && (cur_len_q != '0);
        mem_req   = beat_live && (dir ? in_valid : 1'b1);
        beat_take = mem_req && mem_gnt;
    end

    // Walker state machine with per-fragment address and length counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= WK_IDLE;
            idx_q      <= '0;
            cur_addr_q <= '0;
            cur_len_q  <= '0;
            hold_q     <= '0;
        end else begin
            unique case (st_q)
                WK_IDLE: if (start) begin
                    idx_q <= '0;
                    st_q  <= WK_LOAD;
                end
                WK_LOAD: begin
                    cur_addr_q <= desc_addr;
                    cur_len_q  <= desc_len;
                    st_q       <= WK_RUN;
                end
                WK_RUN: begin
                    if (cur_len_q == '0) begin
                        st_q <= WK_NEXT;
                    end else if (beat_take) begin
                        cur_addr_q <= cur_addr_q + ADDR_W'(1);
                        cur_len_q  <= cur_len_q - LEN_W'(1);
                        if (!dir) st_q <= WK_WAIT;
                    end
                end
                WK_WAIT: if (mem_rvalid) begin
                    hold_q <= mem_rdata;
                    st_q   <= WK_PUSH;
                end
                WK_PUSH: if (out_ready) st_q <= WK_RUN;
                WK_NEXT: begin
                    if (last_ent) begin
                        st_q <= WK_IDLE;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                        st_q  <= WK_LOAD;
                    end
                end
                default: st_q <= WK_IDLE;
            endcase
        end
    end

    assign rd_idx    = idx_q;
    assign busy      = (st_q != WK_IDLE);
    assign finish    = (st_q == WK_NEXT) && last_ent;
    assign mem_we    = dir;
    assign mem_addr  = cur_addr_q;
    assign mem_wdata = in_data;
    assign in_ready  = beat_live && dir && mem_gnt;
    assign out_valid = (st_q == WK_PUSH);
    assign out_data  = hold_q;
endmodule

// File: rtl/sg_dma_engine.sv
// Top of the scatter-gather copy engine: register file with descriptor
// table plus the fragment walker. irq mirrors the sticky done flag.
// Assumes: a single master port and no address translation.
module sg_dma_engine #(
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 16,
    parameter int DATA_W   = 32,
    parameter int MAX_FRAG = 16,
    localparam int IDX_W   = $clog2(MAX_FRAG),
    localparam int CNT_W   = $clog2(MAX_FRAG + 1),
    localparam int REG_AW  = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              strm_out_valid,
    output logic [DATA_W-1:0] strm_out_data,
    input  logic              strm_out_ready,
    input  logic              strm_in_valid,
    input  logic [DATA_W-1:0] strm_in_data,
    output logic              strm_in_ready
);
    logic              start_w, dir_w, busy_w, finish_w, done_w, err_w;
    logic [CNT_W-1:0]  count_w;
    logic [IDX_W-1:0]  idx_w;
    logic [ADDR_W-1:0] daddr_w;
    logic [LEN_W-1:0]  dlen_w;

    sg_dma_regs #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_FRAG(MAX_FRAG)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .busy(busy_w), .finish(finish_w), .rd_idx(idx_w),
        .start(start_w), .dir(dir_w), .count(count_w),
        .desc_addr(daddr_w), .desc_len(dlen_w),
        .done(done_w), .err(err_w)
    );

    sg_dma_walker #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .MAX_FRAG(MAX_FRAG)
    ) u_walk (
        .clk(clk), .rst_n(rst_n),
        .start(start_w), .dir(dir_w), .count(count_w), .rd_idx(idx_w),
        .desc_addr(daddr_w), .desc_len(dlen_w),
        .busy(busy_w), .finish(finish_w),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .out_valid(strm_out_valid), .out_data(strm_out_data), .out_ready(strm_out_ready),
        .in_valid(strm_in_valid), .in_data(strm_in_data), .in_ready(strm_in_ready)
    );

    assign irq = done_w;
endmodule

// File: rtl/sg_dma_checker.sv
// Protocol and status checker for the scatter-gather engine, bound to the
// top module. Observes ports and the busy, done and error flags.
module sg_dma_checker #(
    parameter int REG_AW = 6,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              irq,
    input logic              reg_wr_en,
    input logic [REG_AW-1:0] reg_addr,
    input logic              wdata_b1,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data
);
    logic clr_done;
    assign clr_done = reg_wr_en && (reg_addr == REG_AW'(1)) && wdata_b1;

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);                                              // R2
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));       // R3
    AST_RD_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && !mem_gnt |=> mem_req && $stable(mem_addr)); // R5
    AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !busy && $fell(busy));                            // R7
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !clr_done |=> irq);                                        // R8
    AST_ERR_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !busy);                                            // R9
endmodule

bind sg_dma_engine sg_dma_checker #(
    .REG_AW(REG_AW), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy_w), .done(done_w), .err(err_w), .irq(irq),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .wdata_b1(reg_wdata[1]),
    .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
    .out_valid(strm_out_valid), .out_ready(strm_out_ready), .out_data(strm_out_data)
);

// File: tb/test_sg_dma_engine.sv
// Bench for sg_dma_engine: a behavioural model built from queues of the
// expected memory beats and stream words, compared on every clock.
module test_sg_dma_engine;
    localparam logic [31:0] RKEY  = 32'h5A5A_0000;
    localparam logic [31:0] WBASE = 32'hC0DE_0000;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        irq, mem_req, mem_we, mem_gnt = 1'b0, mem_rvalid = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        strm_out_valid, strm_out_ready = 1'b0, strm_in_valid = 1'b0, strm_in_ready;
    logic [31:0] strm_out_data, strm_in_data = '0;

    int checks = 0, errors = 0, cyc = 0;
    logic [31:0] exp_addr[$], exp_data[$];
    logic        exp_dir = 1'b0;
    logic        pend_rd = 1'b0, in_adv = 1'b0;
    logic [31:0] pend_data = '0, in_word = '0;

    always #2 clk = ~clk;

    sg_dma_engine i_sg_dma_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .strm_out_valid(strm_out_valid), .strm_out_data(strm_out_data),
        .strm_out_ready(strm_out_ready), .strm_in_valid(strm_in_valid),
        .strm_in_data(strm_in_data), .strm_in_ready(strm_in_ready)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory and stream responders, driven at the falling edge
    always @(negedge clk) begin
        cyc++;
        mem_rvalid     = pend_rd;
        mem_rdata      = pend_data;
        pend_rd        = 1'b0;
        mem_gnt        = (cyc % 3) != 1;
        strm_out_ready = (cyc % 4) != 2;
        if (in_adv) begin in_word = in_word + 1; in_adv = 1'b0; end
        strm_in_data   = in_word;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Per-cycle comparison against the expected beat queues
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (mem_req && mem_gnt) begin
                if (exp_addr.size() == 0) begin
                    chk(0, "R6/R9 unexpected memory beat", mem_addr, 32'hFFFF_FFFF);
                end else begin
                    logic [31:0] ea;
                    ea = exp_addr.pop_front();
                    chk(mem_addr == ea, "R3/R5 beat address", mem_addr, ea);
                    chk(mem_we == exp_dir, "R3/R4 beat direction", 32'(mem_we), 32'(exp_dir));
                    if (exp_dir) begin
                        logic [31:0] ed;
                        ed = exp_data.pop_front();
                        chk(mem_wdata == ed, "R4 write data", mem_wdata, ed);
                        chk(strm_in_ready, "R4 stream word taken", 32'(strm_in_ready), 32'd1);
                        in_adv = 1'b1;
                    end else begin
                        pend_rd   = 1'b1;
                        pend_data = mem_addr ^ RKEY;
                    end
                end
            end
            if (strm_out_valid && strm_out_ready) begin
                if (exp_data.size() == 0 || exp_dir) begin
                    chk(0, "R3 unexpected stream word", strm_out_data, 32'hFFFF_FFFF);
                end else begin
                    logic [31:0] ed;
                    ed = exp_data.pop_front();
                    chk(strm_out_data == ed, "R3 stream data", strm_out_data, ed);
                end
            end
            if ((exp_addr.size() + exp_data.size()) != 0 && irq)
                chk(0, "R7 irq before last word", 32'(irq), 32'd0);
        end
    end

    task automatic reg_wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic set_desc(input int i, input logic [31:0] a, input logic [31:0] n);
        reg_wr(6'(32 + 2 * i), a);
        reg_wr(6'(33 + 2 * i), n);
    endtask

    task automatic expect_frag(input logic [31:0] a, input int n);
        for (int k = 0; k < n; k++) begin
            exp_addr.push_back(a + 32'(k));
            if (exp_dir) exp_data.push_back(WBASE + 32'(exp_data.size()));
            else         exp_data.push_back((a + 32'(k)) ^ RKEY);
        end
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!irq && n < 5000) begin @(negedge clk); n++; end
        #1;
        chk(irq == 1'b1, req, 32'(irq), 32'd1);
        chk(exp_addr.size() == 0 && exp_data.size() == 0, {req, " all words moved"},
            32'(exp_addr.size() + exp_data.size()), 32'd0);
    endtask

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        #1;
        chk(irq == 1'b0 && mem_req == 1'b0, "R2 reset quiet", {30'd0, irq, mem_req}, 32'd0);
        rst_n = 1'b1;
        reg_rd(6'd1, v);  chk(v == 32'd0, "R1 status after reset", v, 32'd0);
        reg_rd(6'd34, v); chk(v == 32'd0, "R1 table after reset", v, 32'd0);

        // R1: table and count write/read-back
        set_desc(0, 32'h0000_1000, 4);
        set_desc(1, 32'h0000_2F00, 1);
        set_desc(2, 32'h0000_0080, 3);
        reg_wr(6'd2, 3);
        reg_rd(6'd32, v); chk(v == 32'h1000, "R1 desc0 address", v, 32'h1000);
        reg_rd(6'd35, v); chk(v == 32'd1, "R1 desc1 length", v, 32'd1);
        reg_rd(6'd36, v); chk(v == 32'h80, "R1 desc2 address", v, 32'h80);
        reg_rd(6'd2, v);  chk(v == 32'd3, "R1 count", v, 32'd3);

        // R2, R3, R7: memory to stream over three scattered fragments
        exp_dir = 1'b0;
        expect_frag(32'h1000, 4); expect_frag(32'h2F00, 1); expect_frag(32'h80, 3);
        reg_wr(6'd0, 32'h1);
        reg_rd(6'd1, v); chk(v[0] == 1'b1, "R2 busy after start", v, 32'h1);
        wait_done("R7 read transfer done");
        reg_rd(6'd1, v); chk(v == 32'h2, "R7 status done and idle", v, 32'h2);

        // R8: irq is sticky until bit 1 of status is written
        repeat (5) @(negedge clk);
        #1 chk(irq == 1'b1, "R8 irq held", 32'(irq), 32'd1);
        reg_wr(6'd1, 32'h4);
        #1 chk(irq == 1'b1, "R8 irq kept by err clear", 32'(irq), 32'd1);
        reg_wr(6'd1, 32'h2);
        #1 chk(irq == 1'b0, "R8 irq cleared", 32'(irq), 32'd0);

        // R4, R6: stream to memory with a zero-length middle entry
        set_desc(0, 32'h0000_4000, 2);
        set_desc(1, 32'h0000_5000, 0);
        set_desc(2, 32'h0000_6010, 5);
        in_word = WBASE; exp_dir = 1'b1;
        expect_frag(32'h4000, 2); expect_frag(32'h6010, 5);
        strm_in_valid = 1'b1;
        reg_wr(6'd0, 32'h3);
        wait_done("R4 write transfer done");
        strm_in_valid = 1'b0;
        reg_wr(6'd1, 32'h2);

        // R10: writes while busy are ignored
        set_desc(0, 32'h0000_7000, 20);
        reg_wr(6'd2, 1);
        exp_dir = 1'b0;
        expect_frag(32'h7000, 20);
        reg_wr(6'd0, 32'h1);
        reg_wr(6'd32, 32'hDEAD);
        reg_wr(6'd2, 5);
        reg_wr(6'd0, 32'h3);
        wait_done("R10 transfer unaffected");
        reg_rd(6'd32, v); chk(v == 32'h7000, "R10 table write ignored", v, 32'h7000);
        reg_rd(6'd2, v);  chk(v == 32'd1, "R10 count write ignored", v, 32'd1);
        reg_rd(6'd0, v);  chk(v == 32'd0, "R10 control write ignored", v, 32'd0);
        reg_wr(6'd1, 32'h2);

        // R9: invalid counts set error and move nothing
        reg_wr(6'd2, 0);
        reg_wr(6'd0, 32'h1);
        reg_rd(6'd1, v); chk(v == 32'h4, "R9 count 0 error, not busy", v, 32'h4);
        reg_wr(6'd1, 32'h4);
        reg_rd(6'd1, v); chk(v == 32'h0, "R9 error cleared", v, 32'h0);
        reg_wr(6'd2, 17);
        reg_wr(6'd0, 32'h1);
        reg_rd(6'd1, v); chk(v == 32'h4, "R9 count 17 error", v, 32'h4);
        repeat (4) @(negedge clk);
        #1 chk(irq == 1'b0, "R9 no irq on error", 32'(irq), 32'd0);
        reg_wr(6'd1, 32'h4);

        // R11: all sixteen entries in index order
        for (int i = 0; i < 16; i++) set_desc(i, 32'h0001_0000 + 32'(i * 64), 2);
        reg_wr(6'd2, 16);
        exp_dir = 1'b0;
        for (int i = 0; i < 16; i++) expect_frag(32'h0001_0000 + 32'(i * 64), 2);
        reg_wr(6'd0, 32'h1);
        wait_done("R11 sixteen fragments done");
        reg_rd(6'd1, v); chk(v == 32'h2, "R11 final status", v, 32'h2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule